// File: doc/BRIEF.md
# Virtual Interrupt Completion Unit

This unit sits in a CPU interface and retires virtual Group 0 interrupts. Each acknowledge that returns a real interrupt ID records that ID as the one awaiting completion and marks the acknowledged priority level as active. Acknowledges that return a special ID change nothing. The active levels are kept as one bit per priority level. The running priority is the lowest-numbered active level, or all ones when no level is active.

Software retires an interrupt by writing a 64-bit completion word. Only the low 24 bits carry the ID. When the narrow-ID setting is on, bits [23:16] of that ID are forced to zero as well. A write whose ID equals the tracked acknowledge removes the top active level. When the completion-mode input is 0, the same write also emits a one-cycle deactivate strobe for the ID. When the mode is 1, the write only removes the level, and a later deactivate request emits the strobe. A write that does not match raises a sticky error flag and leaves all state as it was.

Top module: `veoi_unit`

## Requirements
- R1: After reset the running priority is all ones, the error flag is 0, no priority level is active and no deactivate strobe is issued.
- R2: An acknowledge with a non-special ID sets the active bit of its priority level. One cycle later the running priority shows the lowest-numbered active level.
- R3: An acknowledge whose ID (after masking) is 1020 to 1023 sets no active bit and does not replace the tracked ID.
- R4: Bits [63:24] of the completion word have no effect.
- R5: When narrow-ID mode is 1, bits [23:16] are treated as zero in acknowledge IDs, completion IDs and deactivate-request IDs. Strobed IDs then have those bits at zero.
- R6: With completion mode 0, a matching completion clears the lowest-numbered active bit. In the next cycle it also drives a deactivate strobe that carries the ID and lasts exactly one cycle.
- R7: With completion mode 1, a matching completion clears the lowest-numbered active bit and issues no deactivate strobe.
- R8: With completion mode 1, a deactivate request drives a one-cycle deactivate strobe carrying its masked ID in the next cycle. With mode 0 the request is ignored.
- R9: A completion is matching only if a tracked ID exists and equals the masked completion ID. A matching completion consumes the tracked ID. A non-matching completion sets the error flag, keeps the active levels and the tracked ID, and issues no strobe.
- R10: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id16 | input | 1 | 1: IDs are 16 bits wide |
| eoi_mode | input | 1 | 1: completion only removes the priority level |
| ack_valid | input | 1 | Acknowledge read completed |
| ack_id | input | 24 | ID returned by the acknowledge |
| ack_prio | input | 5 | Priority level of the acknowledged interrupt |
| eoi_valid | input | 1 | Completion write |
| eoi_data | input | 64 | Completion write data |
| dir_valid | input | 1 | Deactivate request |
| dir_id | input | 24 | ID to deactivate |
| run_prio | output | 5 | Running priority, all ones when idle |
| deact_valid | output | 1 | One-cycle deactivate strobe |
| deact_id | output | 24 | ID being deactivated |
| mismatch | output | 1 | Sticky completion-mismatch flag |

## Verification
The assertions assume that an acknowledge and a completion do not arrive in the same cycle. They also assume that the completion mode does not change in a cycle where a completion and a deactivate request arrive together. The bench issues at most one request per cycle, so it never creates either case. The random phase mostly writes the tracked ID back, with random reserved bits. It sometimes writes a wrong ID, sometimes acknowledges a special ID, and changes the narrow-ID and mode settings between requests.

// File: rtl/veoi_unit.sv
module veoi_unit #(
  parameter int ID_W       = 24,
  parameter int PRIO_W     = 5,
  parameter int SPECIAL_LO = 1020,
  parameter int SPECIAL_HI = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id16,
  input  logic              eoi_mode,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_id,
  input  logic [PRIO_W-1:0] ack_prio,
  input  logic              eoi_valid,
  input  logic [63:0]       eoi_data,
  input  logic              dir_valid,
  input  logic [ID_W-1:0]   dir_id,
  output logic [PRIO_W-1:0] run_prio,
  output logic              deact_valid,
  output logic [ID_W-1:0]   deact_id,
  output logic              mismatch
);
  localparam int LEVELS = 1 << PRIO_W;

  logic [LEVELS-1:0] active, active_low, active_nx;
  logic [ID_W-1:0]   last_ack;
  logic              have_ack;
  logic              unused_hi;

  wire [ID_W-1:0] id_mask = id16 ? {{(ID_W-16){1'b0}}, {16{1'b1}}} : {ID_W{1'b1}};
  wire [ID_W-1:0] ack_m   = ack_id & id_mask;
  wire [ID_W-1:0] eoi_m   = eoi_data[ID_W-1:0] & id_mask;
  wire [ID_W-1:0] dir_m   = dir_id & id_mask;

  assign unused_hi = ^eoi_data[63:ID_W];

  wire ack_real  = ack_valid &&
                   !(ack_m >= ID_W'(SPECIAL_LO) && ack_m <= ID_W'(SPECIAL_HI));
  wire eoi_hit   = eoi_valid && have_ack && (eoi_m == last_ack);
  wire eoi_miss  = eoi_valid && !eoi_hit;
  wire dir_fire  = dir_valid && eoi_mode;
  wire eoi_deact = eoi_hit && !eoi_mode;

  assign active_low = active & (~active + 1'b1);

  always_comb begin
    active_nx = active;
    if (eoi_hit)  active_nx = active_nx & ~active_low;
    if (ack_real) active_nx = active_nx | (LEVELS'(1) << ack_prio);
  end

  always_comb begin
    run_prio = '1;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (active[i]) run_prio = PRIO_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= '0;
      last_ack    <= '0;
      have_ack    <= 1'b0;
      mismatch    <= 1'b0;
      deact_valid <= 1'b0;
      deact_id    <= '0;
    end else begin
      active      <= active_nx;
      deact_valid <= eoi_deact || dir_fire;
      if (eoi_deact)     deact_id <= eoi_m;
      else if (dir_fire) deact_id <= dir_m;
      if (eoi_hit)  have_ack <= 1'b0;
      if (eoi_miss) mismatch <= 1'b1;
      if (ack_real) begin
        last_ack <= ack_m;
        have_ack <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/veoi_unit_chk.sv
module veoi_unit_chk #(
  parameter int ID_W   = 24,
  parameter int PRIO_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id16,
  input logic              eoi_mode,
  input logic              ack_valid,
  input logic              eoi_valid,
  input logic              dir_valid,
  input logic [PRIO_W-1:0] run_prio,
  input logic              deact_valid,
  input logic [ID_W-1:0]   deact_id,
  input logic              mismatch
);
  assert_sticky_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> mismatch);

  assert_err_from_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> $past(eoi_valid));

  assert_err_keeps_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mismatch) && !$past(ack_valid)) |-> $stable(run_prio));

  assert_mode1_no_deact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_mode && !dir_valid) |=> !deact_valid);

  assert_dir_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !eoi_mode && !eoi_valid) |=> !deact_valid);

  assert_deact_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> $past(eoi_valid || (dir_valid && eoi_mode)));

  assert_prio_rise_on_eoi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |=> (run_prio <= $past(run_prio)));

  assert_narrow_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_valid && $past(id16)) |-> (deact_id[ID_W-1:16] == '0));
endmodule

bind veoi_unit veoi_unit_chk #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/veoi_unit_bench.sv
`timescale 1ns/1ps
module veoi_unit_bench;
  logic        clk = 0, rst_n = 0, id16 = 0, eoi_mode = 0;
  logic        ack_valid = 0, eoi_valid = 0, dir_valid = 0;
  logic [23:0] ack_id = 0, dir_id = 0;
  logic [4:0]  ack_prio = 0;
  logic [63:0] eoi_data = 0;
  logic [4:0]  run_prio;
  logic        deact_valid, mismatch;
  logic [23:0] deact_id;

  veoi_unit u_veoi_unit (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] m_act;
  logic [23:0] m_last, m_did;
  logic        m_have, m_mis, m_dv;

  function automatic logic [23:0] msk(input logic [23:0] id, input logic narrow);
    return narrow ? {8'h00, id[15:0]} : id;
  endfunction

  function automatic logic [4:0] top_level(input logic [31:0] a);
    for (int i = 0; i < 32; i++) if (a[i]) return 5'(i);
    return 5'h1f;
  endfunction

  function automatic logic [31:0] drop_top(input logic [31:0] a);
    for (int i = 0; i < 32; i++) if (a[i]) begin a[i] = 1'b0; return a; end
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " run_prio"}, 32'(run_prio), 32'(top_level(m_act)));
    chk({req, " deact_valid"}, 32'(deact_valid), 32'(m_dv));
    if (m_dv) chk({req, " deact_id"}, 32'(deact_id), 32'(m_did));
    chk({req, " mismatch"}, 32'(mismatch), 32'(m_mis));
  endtask

  task automatic model_reset();
    m_act = 0; m_last = 0; m_have = 0; m_mis = 0; m_dv = 0; m_did = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic finish_op(input string req);
    @(negedge clk);
    ack_valid = 0; eoi_valid = 0; dir_valid = 0;
    check_all(req);
  endtask

  task automatic ack(input logic [23:0] id, input logic [4:0] p, input logic nar, input string req);
    logic [23:0] m;
    id16 = nar; ack_valid = 1; ack_id = id; ack_prio = p;
    m = msk(id, nar);
    m_dv = 0;
    if (!(m >= 1020 && m <= 1023)) begin
      m_act[p] = 1'b1; m_last = m; m_have = 1;
    end
    finish_op(req);
  endtask

  task automatic eoi(input logic [63:0] d, input logic md, input logic nar, input string req);
    logic [23:0] m;
    id16 = nar; eoi_mode = md; eoi_valid = 1; eoi_data = d;
    m = msk(d[23:0], nar);
    m_dv = 0;
    if (m_have && m == m_last) begin
      m_act = drop_top(m_act); m_have = 0; m_dv = !md; m_did = m;
    end else m_mis = 1;
    finish_op(req);
  endtask

  task automatic dir(input logic [23:0] id, input logic md, input logic nar, input string req);
    id16 = nar; eoi_mode = md; dir_valid = 1; dir_id = id;
    m_dv = md; m_did = msk(id, nar);
    finish_op(req);
  endtask

  task automatic idle(input string req);
    m_dv = 0;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    do_reset();
    check_all("R1 reset");

    ack(24'd40, 5'd7, 0, "R2 first ack");
    ack(24'd41, 5'd3, 0, "R2 nested ack");
    eoi({40'hABCDE_12345, 24'd41}, 0, 0, "R4 R6 mode0 eoi");
    idle("R6 strobe one cycle");
    ack(24'd50, 5'd2, 0, "R2 ack");
    ack(24'd1022, 5'd1, 0, "R3 special ack ignored");
    ack(24'd1020, 5'd0, 0, "R3 special ack low edge");
    eoi(64'd50, 0, 0, "R3 tracked id kept");
    ack(24'd60, 5'd4, 0, "R2 ack");
    eoi(64'd60, 1, 0, "R7 mode1 no deact");
    dir(24'd60, 1, 0, "R8 dir mode1");
    dir(24'd61, 0, 0, "R8 dir mode0 ignored");
    ack(24'h123456, 5'd6, 1, "R5 narrow ack");
    eoi(64'h00FF3456, 0, 1, "R5 narrow eoi");
    dir(24'hAB0007, 1, 1, "R5 narrow dir");
    ack(24'h0103FE, 5'd9, 1, "R3 R5 narrow special");
    ack(24'd70, 5'd5, 0, "R2 ack");
    eoi(64'd71, 0, 0, "R9 wrong id");
    idle("R10 sticky");
    eoi(64'd70, 0, 0, "R9 state kept");
    eoi(64'd70, 0, 0, "R9 consumed id");
    idle("R10 sticky again");
    do_reset();
    check_all("R1 second reset");

    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 10;
      logic nar = ($urandom % 4) == 0;
      logic md  = $urandom % 2;
      if (op < 4) begin
        logic [23:0] id = ($urandom % 5 == 0) ? 24'(1020 + $urandom % 4) : 24'($urandom);
        ack(id, 5'($urandom), nar, "R2 R3 random ack");
      end else if (op < 8) begin
        logic [63:0] d = {$urandom, $urandom};
        if ($urandom % 4 != 0) d[23:0] = m_last;
        eoi(d, md, nar, "R4 R6 R7 R9 random eoi");
      end else if (op < 9) begin
        dir(24'($urandom), md, nar, "R8 random dir");
      end else idle("R6 R10 random idle");
      if (n == 200) begin do_reset(); check_all("R1 mid reset"); end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule